// File: doc/BRIEF.md
# Nestable Level-Masked Interrupt Controller

This controller sits between a bank of interrupt request lines and the single active-low IRQ input of a CPU core. Each source carries a programmable priority level. Among the sources that are requesting, the block picks the one whose level is highest and strictly above a software-owned level mask. It then latches a flag, records the winner's level and index, and pulls the IRQ output low.

While the flag is set, arbitration is frozen. The recorded level and index stay fixed even when new requests arrive. A handler first clears its source and then clears the flag with a bus write. This releases the IRQ line, and the block decides again in the next cycle. To nest interrupts, a handler saves the mask, copies the current level into it and re-enables interrupts in the core. From then on only strictly higher levels can interrupt it. It restores the saved mask on exit.

The register bus is synchronous for writes and combinational for reads.

Top module: `irq_level_ctrl`

## Requirements
- R1: After reset, every level register and the mask read 0, the flag reads 0, the current-level and index registers read 0, and `irq_n` is 1.
- R2: Addresses 0 to NSRC-1 hold one level per source in bits [3:0]. Address NSRC holds the mask in bits [3:0]. Both are writable and read back the written value. A source with level 0 never raises an interrupt.
- R3: A source is eligible only when its request line is high and its level is strictly greater than the mask. A level equal to the mask is not eligible.
- R4: Among eligible sources, the highest level wins. Between sources with equal levels, the lowest index wins.
- R5: With the flag clear and an eligible source present in cycle t, the flag is set at the edge ending cycle t, and `irq_n` goes low one edge later.
- R6: While the flag is set, the current-level register (address NSRC+1) and the index register (address NSRC+2) hold their values, whatever the requests do.
- R7: Writing 0 in bit 0 at address NSRC+3 clears the flag, and `irq_n` returns high one edge later. Writing 1 there has no effect. The flag is read back in bit 0 of that address.
- R8: After the flag is cleared, arbitration re-runs in the next cycle. A source that was dropped before the clear does not win again.
- R9: Writes to the current-level and index addresses have no effect.
- R10: Reads are combinational. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | NSRC | Request lines, one per source, active high |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Register address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for `addr` |
| irq_n | output | 1 | IRQ to the core, active low |

## Verification
The directed patterns each separate one specific fault:
- Two equal-level requests separate a lowest-index tie break from a highest-index one.
- A later, higher-level request raised while the flag is set separates a frozen arbiter from a free-running one.
- Copying the current level into the mask separates strict from non-strict comparison. The pending equal-level source must then stay silent until the mask drops by one.
- A zero-level requester and writes to the read-only addresses show that the ignored inputs leave the outputs unchanged.

A long phase of random requests and register writes is then compared against a behavioural model on every clock.

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl #(
  parameter int NSRC  = 32,
  parameter int LVL_W = 4,
  parameter int DW    = 8,
  localparam int AW   = $clog2(NSRC + 4),
  localparam int IW   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_req,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic            irq_n
);
  localparam logic [AW-1:0] A_MASK = AW'(NSRC);
  localparam logic [AW-1:0] A_CUR  = AW'(NSRC + 1);
  localparam logic [AW-1:0] A_IDX  = AW'(NSRC + 2);
  localparam logic [AW-1:0] A_FLAG = AW'(NSRC + 3);

  logic [LVL_W-1:0] lvl_q [NSRC];
  logic [LVL_W-1:0] mask_q, cur_q, best_lvl;
  logic [IW-1:0]    idx_q, best_idx;
  logic             flag_q, any_elig, clr_wr;

  always_comb begin
    best_lvl = mask_q;
    best_idx = '0;
    for (int i = 0; i < NSRC; i++)
      if (src_req[i] && lvl_q[i] > best_lvl) begin
        best_lvl = lvl_q[i];
        best_idx = IW'(i);
      end
  end

  assign any_elig = (best_lvl != mask_q);
  assign clr_wr   = wr_en && addr == A_FLAG && !wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) lvl_q[i] <= '0;
      mask_q <= '0;
    end else if (wr_en) begin
      if (addr < A_MASK) lvl_q[addr[IW-1:0]] <= wdata[LVL_W-1:0];
      else if (addr == A_MASK) mask_q <= wdata[LVL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      cur_q  <= '0;
      idx_q  <= '0;
      irq_n  <= 1'b1;
    end else begin
      irq_n <= !flag_q;
      if (flag_q) begin
        if (clr_wr) flag_q <= 1'b0;
      end else if (any_elig) begin
        flag_q <= 1'b1;
        cur_q  <= best_lvl;
        idx_q  <= best_idx;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr < A_MASK)       rdata = DW'(lvl_q[addr[IW-1:0]]);
    else if (addr == A_MASK) rdata = DW'(mask_q);
    else if (addr == A_CUR)  rdata = DW'(cur_q);
    else if (addr == A_IDX)  rdata = DW'(idx_q);
    else if (addr == A_FLAG) rdata = DW'(flag_q);
  end

  p_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !clr_wr |=> flag_q && $stable(cur_q) && $stable(idx_q));
  p_strict_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> cur_q > $past(mask_q));
  p_irq_lag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |=> $fell(irq_n));
  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && clr_wr |=> !flag_q ##1 irq_n);
endmodule

// File: tb/test_irq_level_ctrl.sv
module test_irq_level_ctrl;
  localparam int PERIOD = 10;
  localparam int NSRC = 32;
  localparam int AW = $clog2(NSRC + 4);
  localparam int DW = 8;
  localparam int AM = NSRC, AC = NSRC + 1, AI = NSRC + 2, AF = NSRC + 3;

  logic clk = 0, rst_n = 0, wr_en = 0, irq_n;
  logic [NSRC-1:0] src_req = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  int tests = 0, fails = 0;

  int m_lvl [NSRC];
  int m_mask, m_cur, m_idx, m_flag, m_irqn;

  always #(PERIOD/2) clk = ~clk;

  irq_level_ctrl #(.NSRC(NSRC)) i_irq_level_ctrl (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_n(irq_n));

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_lvl[i]) m_lvl[i] = 0;
      m_mask = 0; m_cur = 0; m_idx = 0; m_flag = 0; m_irqn = 1;
    end else begin
      int bl, bi, nf;
      bl = -1; bi = 0;
      for (int i = 0; i < NSRC; i++)
        if (src_req[i] && m_lvl[i] != 0 && m_lvl[i] > m_mask && m_lvl[i] > bl) begin
          bl = m_lvl[i]; bi = i;
        end
      m_irqn = m_flag ? 0 : 1;
      if (m_flag) begin
        if (wr_en && addr == AF && wdata[0] == 0) m_flag = 0;
      end else if (bl >= 0) begin
        m_flag = 1; m_cur = bl; m_idx = bi;
      end
      if (wr_en) begin
        if (addr < AM) m_lvl[addr] = wdata[3:0];
        else if (addr == AM) m_mask = wdata[3:0];
      end
    end
  end

  function automatic int m_read(int a);
    if (a < AM) return m_lvl[a];
    if (a == AM) return m_mask;
    if (a == AC) return m_cur;
    if (a == AI) return m_idx;
    if (a == AF) return m_flag;
    return 0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare comb read and irq_n against model
  task automatic step(string tag, bit we = 0, int a = 0, int d = 0);
    @(negedge clk);
    wr_en = we; addr = AW'(a); wdata = DW'(d);
    #1;
    chk({tag, " irq_n"}, irq_n, m_irqn);
    chk({tag, " rdata"}, rdata, m_read(a));
  endtask

  task automatic rd(string tag, int a, int exp);
    step(tag, 0, a);
    chk({tag, " direct"}, rdata, exp);
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd("R1 mask", AM, 0);
    rd("R1 flag", AF, 0);
    rd("R1 lvl", 5, 0);
    chk("R1 irq_n", irq_n, 1);
    // R2 program levels
    step("R2", 1, 3, 5);
    step("R2", 1, 7, 5);
    step("R2", 1, 10, 9);
    step("R2", 1, 20, 2);
    rd("R2 readback", 10, 9);
    rd("R10 unmapped", NSRC + 4, 0);
    // R4 tie break, R5 timing
    src_req[3] = 1; src_req[7] = 1;
    step("R5");
    rd("R5 flag", AF, 1);
    chk("R5 irq_n", irq_n, 0);
    rd("R4 cur", AC, 5);
    rd("R4 idx", AI, 3);
    // R6 freeze
    src_req[10] = 1;
    repeat (4) step("R6");
    rd("R6 idx", AI, 3);
    rd("R6 cur", AC, 5);
    // nest: mask = current level, drop source, clear flag
    step("R8", 1, AM, 5);
    src_req[3] = 0;
    step("R7 clear", 1, AF, 0);
    step("R8");
    step("R8");
    rd("R8 idx", AI, 10);
    rd("R3 cur", AC, 9);
    // R7 writing 1 ignored, R9 read-only
    step("R7", 1, AF, 1);
    rd("R7 flag", AF, 1);
    step("R9", 1, AC, 3);
    step("R9", 1, AI, 7);
    rd("R9 cur", AC, 9);
    rd("R9 idx", AI, 10);
    // R3 equal level blocked
    src_req[10] = 0;
    step("R7 clear", 1, AF, 0);
    repeat (3) step("R3");
    chk("R3 irq_n", irq_n, 1);
    rd("R3 flag", AF, 0);
    step("R3", 1, AM, 4);
    repeat (2) step("R3");
    rd("R3 idx", AI, 7);
    chk("R3 irq_n", irq_n, 0);
    // R2 level zero disables
    step("R2", 1, 7, 0);
    step("R2", 1, AM, 0);
    src_req = '0; src_req[7] = 1;
    step("R7 clear", 1, AF, 0);
    repeat (3) step("R2");
    rd("R2 lvl0 flag", AF, 0);
    chk("R2 lvl0 irq_n", irq_n, 1);
    // random phase, model compared every cycle
    for (int n = 0; n < 4000; n++) begin
      int a, d;
      bit we;
      if (n % 8 == 0) src_req = $urandom;
      we = ($urandom % 3) == 0;
      a = $urandom % (NSRC + 5);
      d = $urandom;
      if (a == AF && ($urandom % 2)) d = 0;
      step("R4 R8 random", we, a, d);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule